// File: doc/BRIEF.md
# Bidirectional Thermometer Strength Shifter

This block holds the strength setting of a calibrated output driver as a thermometer code: a word in which every set bit sits below every clear bit, so the count of ones picks how many driver legs are switched on. Comparator decision logic outside the block asks for one more leg (`up_req` high, `dn_req` low) or one fewer (`up_req` low, `dn_req` high). Each request that is accepted moves the boundary between ones and zeros by one position on the rising clock edge.

Requests are taken only while calibration is running, which is the state in which the active-low transmit-mode input `tx_mode_n` is high. Once the transmitter goes into normal operation (`tx_mode_n` low) the word is frozen in flip-flops for as long as that lasts. A request in which both lines carry the same level is treated as invalid and is ignored. A registered flag reports when the code sits at either end of its range. Growing the code moves a one into the lowest bit and each bit takes the value of the bit below it. Shrinking the code moves a zero into the highest bit and each bit takes the value of the bit above it. Because of this the word cannot leave the thermometer form, and a request past either end changes nothing.

Top module: `thermo_strength_shifter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `strength` becomes all zeros and `at_limit` becomes 1 at that edge.
- R2: With `tx_mode_n`=1, `up_req`=1 and `dn_req`=0 at an edge, `strength[0]` becomes 1 and each `strength[i]` (i>0) takes the former `strength[i-1]`.
- R3: With `tx_mode_n`=1, `up_req`=0 and `dn_req`=1 at an edge, `strength[WIDTH-1]` becomes 0 and each `strength[i]` (i<WIDTH-1) takes the former `strength[i+1]`.
- R4: When `up_req` equals `dn_req` at an edge, `strength` keeps its value.
- R5: When `tx_mode_n`=0 at an edge, `strength` keeps its value, however many cycles this lasts and whatever the requests are.
- R6: A grow request at all ones, or a shrink request at all zeros, leaves `strength` unchanged.
- R7: `at_limit` is 1 exactly when `strength` is all zeros or all ones, and it changes on the same edge as `strength`.
- R8: `strength` is always a thermometer code: no bit is 1 above a bit that is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_req | input | 1 | Grow request from the comparator decision logic |
| dn_req | input | 1 | Shrink request; the complement of `up_req` when the request is valid |
| tx_mode_n | input | 1 | Active-low transmit mode; high means calibration is running |
| strength | output | WIDTH | Thermometer-coded driver strength, bit 0 fills first |
| at_limit | output | 1 | Registered flag: the code is all zeros or all ones |

## Verification
The bench builds the block with its default `WIDTH` of 8. At this width a single pass walks the code from empty to full and back, so both fill constants and both saturation ends are reached in a few dozen cycles. Along the way it mixes in invalid request pairs and periods with transmit mode active, and each of them must leave the current code untouched.

// File: rtl/thermo_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the thermometer strength shifter.
// Assumes: one move decision per clock edge.
package thermo_pkg;

    // Decoded move command applied to the strength word.
    typedef enum logic [1:0] {
        MOVE_HOLD = 2'd0,
        MOVE_GROW = 2'd1,
        MOVE_SHRINK = 2'd2
    } move_e;

endpackage

// File: rtl/thermo_req_decode.sv
`timescale 1ns/1ps
// Module: thermo_req_decode
// Turns the raw request lines and the transmit-mode gate into one move
// command. Assumes the requests are already synchronous to clk.
module thermo_req_decode
    import thermo_pkg::*;
(
    input  logic  up_req,
    input  logic  dn_req,
    input  logic  tx_mode_n,
    output move_e move
);

    logic pair_valid;
    logic cal_active;

    // Purpose: qualify the request by complementarity and calibration gate.
    always_comb begin
        pair_valid = up_req ^ dn_req;
        cal_active = tx_mode_n;
        if (cal_active && pair_valid) begin
            move = up_req ? MOVE_GROW : MOVE_SHRINK;
        end else begin
            move = MOVE_HOLD;
        end
    end

endmodule

// File: rtl/thermo_shift_reg.sv
`timescale 1ns/1ps
// Module: thermo_shift_reg
// Bidirectional shift register with a constant one fed in at bit 0 on a
// grow and a constant zero fed in at the top bit on a shrink. Holds its
// value in static flip-flops whenever the command is HOLD.
// Assumes WIDTH >= 2.
module thermo_shift_reg
    import thermo_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  move_e            move,
    output logic [WIDTH-1:0] word_q,
    output logic [WIDTH-1:0] word_d
);

    localparam int TOP = WIDTH - 1;
    localparam logic [WIDTH-1:0] LSB_ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    // Per-bit next-value multiplexer; end bits take fixed fill values.
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        logic from_below;
        logic from_above;
        if (gi == 0) begin : g_low_end
            assign from_below = 1'b1;
        end else begin : g_low_mid
            assign from_below = word_q[gi-1];
        end
        if (gi == TOP) begin : g_high_end
            assign from_above = 1'b0;
        end else begin : g_high_mid
            assign from_above = word_q[gi+1];
        end

        // Purpose: select the next value of this bit from the move command.
        always_comb begin
            unique case (move)
                MOVE_GROW:   word_d[gi] = from_below;
                MOVE_SHRINK: word_d[gi] = from_above;
                default:     word_d[gi] = word_q[gi];
            endcase
        end
    end

    // Purpose: store the strength word; synchronous clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> word_q == '0); // R1
    AST_GROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        move == MOVE_GROW |=> word_q == (($past(word_q) << 1) | LSB_ONE)); // R2
    AST_SHRINK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        move == MOVE_SHRINK |=> word_q == ($past(word_q) >> 1)); // R3
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        move == MOVE_HOLD |=> $stable(word_q)); // R5
    AST_THERMO_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (word_q & (word_q + LSB_ONE)) == '0); // R8

endmodule

// File: rtl/thermo_limit_flag.sv
`timescale 1ns/1ps
// Module: thermo_limit_flag
// Registers a flag that says whether the word loaded at this edge sits at
// either end of the range, so the flag lines up with the word register.
// Assumes the incoming next word is a thermometer code.
module thermo_limit_flag #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] word_d,
    output logic             limit_q
);

    logic limit_d;

    // Purpose: detect the empty and full codes on the next word.
    always_comb begin
        limit_d = (word_d == '0) || (&word_d);
    end

    // Purpose: register the flag; reset state is the empty code, a limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= 1'b1;
        end else begin
            limit_q <= limit_d;
        end
    end

endmodule

// File: rtl/thermo_strength_shifter.sv
`timescale 1ns/1ps
// Module: thermo_strength_shifter (top)
// Driver-strength register for output impedance calibration. Moves a
// thermometer code up or down by one step per accepted request while
// calibration runs, and freezes it while transmit mode is active.
// Assumes all inputs are synchronous to clk; WIDTH >= 2.
module thermo_strength_shifter
    import thermo_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_req,
    input  logic             dn_req,
    input  logic             tx_mode_n,
    output logic [WIDTH-1:0] strength,
    output logic             at_limit
);

    move_e            move;
    logic [WIDTH-1:0] word_d;

    thermo_req_decode u_decode (
        .up_req    (up_req),
        .dn_req    (dn_req),
        .tx_mode_n (tx_mode_n),
        .move      (move)
    );

    thermo_shift_reg #(.WIDTH(WIDTH)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .move   (move),
        .word_q (strength),
        .word_d (word_d)
    );

    thermo_limit_flag #(.WIDTH(WIDTH)) u_limit (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_d  (word_d),
        .limit_q (at_limit)
    );

    AST_INVALID_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req == dn_req) |=> $stable(strength)); // R4
    AST_TX_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_mode_n |=> $stable(strength)); // R5
    AST_SATURATE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (&strength && up_req) |=> &strength); // R6
    AST_SATURATE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (strength == '0 && dn_req) |=> strength == '0); // R6
    AST_LIMIT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        at_limit == ((strength == '0) || (&strength))); // R7

endmodule

// File: tb/tb_thermo_strength_shifter.sv
`timescale 1ns/1ps
module tb_thermo_strength_shifter;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         up_req = 1'b0;
    logic         dn_req = 1'b0;
    logic         tx_mode_n = 1'b0;
    logic [W-1:0] strength;
    logic         at_limit;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    thermo_strength_shifter #(.WIDTH(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .up_req    (up_req),
        .dn_req    (dn_req),
        .tx_mode_n (tx_mode_n),
        .strength  (strength),
        .at_limit  (at_limit)
    );

    // Vector: {up, dn, tx_mode_n, expected strength, expected at_limit}
    localparam int NV = 24;
    localparam logic [11:0] VEC [NV] = '{
        {3'b101, 8'h01, 1'b0},  // R2 first one enters bit 0
        {3'b101, 8'h03, 1'b0},  // R2
        {3'b101, 8'h07, 1'b0},  // R2
        {3'b011, 8'h03, 1'b0},  // R3
        {3'b111, 8'h03, 1'b0},  // R4 both high
        {3'b001, 8'h03, 1'b0},  // R4 both low
        {3'b100, 8'h03, 1'b0},  // R5 grow while transmitting
        {3'b010, 8'h03, 1'b0},  // R5 shrink while transmitting
        {3'b101, 8'h07, 1'b0},
        {3'b101, 8'h0F, 1'b0},
        {3'b101, 8'h1F, 1'b0},
        {3'b101, 8'h3F, 1'b0},
        {3'b101, 8'h7F, 1'b0},
        {3'b101, 8'hFF, 1'b1},  // R7 full
        {3'b101, 8'hFF, 1'b1},  // R6 grow at full
        {3'b011, 8'h7F, 1'b0},  // R3 zero enters top bit
        {3'b011, 8'h3F, 1'b0},
        {3'b011, 8'h1F, 1'b0},
        {3'b011, 8'h0F, 1'b0},
        {3'b011, 8'h07, 1'b0},
        {3'b011, 8'h03, 1'b0},
        {3'b011, 8'h01, 1'b0},
        {3'b011, 8'h00, 1'b1},  // R7 empty
        {3'b011, 8'h00, 1'b1}   // R6 shrink at empty
    };

    task automatic check(input string tag, input logic [W-1:0] exp_s, input logic exp_l);
        n_chk++;
        if (strength !== exp_s || at_limit !== exp_l) begin
            n_bad++;
            $display("FAIL %s: strength=%h at_limit=%b expected strength=%h at_limit=%b",
                     tag, strength, at_limit, exp_s, exp_l);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, sample at the next fall.
    task automatic step(input logic u, input logic d, input logic t);
        up_req = u;
        dn_req = d;
        tx_mode_n = t;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 reset state", 8'h00, 1'b1);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][11], VEC[i][10], VEC[i][9]);
            check($sformatf("R2/R3/R4/R5/R6/R7/R8 vector %0d", i), VEC[i][8:1], VEC[i][0]);
        end

        // R5: long freeze after calibration, requests toggling
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1);
        check("R2 refill to 1F", 8'h1F, 1'b0);
        for (int i = 0; i < 40; i++) step(i[0], ~i[0], 1'b0);
        check("R5 held through transmit", 8'h1F, 1'b0);

        // R1: reset in mid-word, with a grow request present
        up_req = 1'b1; dn_req = 1'b0; tx_mode_n = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-word", 8'h00, 1'b1);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 1'b1);
        check("R2 grow after reset", 8'h01, 1'b0);
        step(1'b0, 1'b1, 1'b1);
        check("R7 back to empty sets flag", 8'h00, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule